// File: doc/BRIEF.md
# Register Window Controller

This block keeps the bookkeeping state of a windowed integer register file: the current window pointer, the four occupancy counters that decide whether a window may move (free-to-save, restorable, clean, and windows belonging to another context), and the two three-bit spill/fill selector fields. The register storage itself lives elsewhere. The block consumes one-cycle request strobes for a window-advancing call (save), a window-retreating return (restore), and a combined return-and-jump (return with a target address). It also accepts privileged writes of any single state field.

For each request the block either moves the window and updates the counters, or leaves every piece of state untouched and emits a one-cycle trap pulse with a nine-bit trap type. Spill and fill trap types carry the selected three-bit selector field merged into bits 4:2 of a base code. The choice between the "other" and "normal" base and field depends on whether the other-context counter is zero. A successful return also reports its target address for the fetch logic. All outputs are registered and change one clock after the request is sampled. The window count is a parameter from 3 to 32.

Top module: `regWindowCtrl`

## Requirements
- R1: While rstN is low, and at the first edge after it, cwp=0, canSave=NUM_WIN-2, canRestore=0, cleanWin=NUM_WIN-1, otherWin=0, both selector fields are 0, and trapValid, trapType, retValid and retTarget are 0.
- R2: A save with canSave nonzero and cleanWin different from canRestore raises cwp by one, lowers canSave by one and raises canRestore by one, all modulo NUM_WIN. No trap is raised and the other fields are unchanged.
- R3: A save with canSave equal to 0 raises a spill trap. If otherWin is nonzero the trap type is 0x0A0 | (wstateOther<<2); otherwise it is 0x080 | (wstateNormal<<2).
- R4: A save with canSave nonzero and cleanWin equal to canRestore raises trap type 0x024. The spill condition of R3 is checked first.
- R5: A restore, or an aligned return, with canRestore equal to 0 raises a fill trap. If otherWin is nonzero the trap type is 0x0E0 | (wstateOther<<2); otherwise it is 0x0C0 | (wstateNormal<<2).
- R6: A restore, or an aligned return, with canRestore nonzero lowers cwp by one, raises canSave by one and lowers canRestore by one, all modulo NUM_WIN.
- R7: A return whose target has either of bits 1:0 set raises trap type 0x034, whatever the counters hold.
- R8: A return that moves the window drives retValid high for one cycle with retTarget equal to its target address. Otherwise retValid and retTarget are 0.
- R9: A write (wrEn high) stores wrData into the field picked by wrSel: 0 cwp, 1 canSave, 2 canRestore, 3 cleanWin, 4 otherWin, 5 both selector fields (wrData[2:0] normal, wrData[5:3] other). A cwp value of NUM_WIN or more is stored as NUM_WIN-1, and counter writes keep the low CWP_W bits. wrSel values 6 and 7 change nothing.
- R10: When several strobes arrive in one cycle, only the first in the order save, restore, return, write takes effect, and the rest are dropped.
- R11: A trapping request pulses trapValid for exactly one cycle, one cycle after the request, and changes no state field. trapType is 0 whenever trapValid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| saveReq | input | 1 | Save request strobe |
| restoreReq | input | 1 | Restore request strobe |
| returnReq | input | 1 | Return request strobe |
| returnTarget | input | ADDR_W | Return target address |
| wrEn | input | 1 | State field write strobe |
| wrSel | input | 3 | Field select for a write |
| wrData | input | WR_W | Write value |
| cwp | output | CWP_W | Current window pointer |
| canSave | output | CWP_W | Windows free for save |
| canRestore | output | CWP_W | Windows available to restore |
| cleanWin | output | CWP_W | Clean window count |
| otherWin | output | CWP_W | Windows owned by another context |
| wstateNormal | output | 3 | Normal spill/fill selector |
| wstateOther | output | 3 | Other spill/fill selector |
| trapValid | output | 1 | One-cycle trap request |
| trapType | output | 9 | Trap type code |
| retValid | output | 1 | Successful return pulse |
| retTarget | output | ADDR_W | Target of the successful return |

## Verification
Directed runs of saves until canSave hits zero and of restores until canRestore hits zero tell normal movement apart from spill and fill. They run once with otherWin zero and once with it nonzero, under nonzero selector fields, so that the base choice and the field merge are both observed. Separate cases set cleanWin equal to canRestore with saves still free, send a misaligned return while canRestore is zero, drive colliding strobes, and wrap cwp across both ends. These isolate the clean-window trap, the alignment-first order, the priority order and the modulo arithmetic. A long pseudo-random mix of requests and field writes, checked against a behavioural model on every clock, then covers combinations the directed cases do not reach.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

  typedef enum logic [2:0] {
    FLD_CWP        = 3'd0,
    FLD_CANSAVE    = 3'd1,
    FLD_CANRESTORE = 3'd2,
    FLD_CLEANWIN   = 3'd3,
    FLD_OTHERWIN   = 3'd4,
    FLD_WSTATE     = 3'd5,
    FLD_RSVD6      = 3'd6,
    FLD_RSVD7      = 3'd7
  } fieldSel_e;

  localparam int TT_W = 9;

  localparam logic [TT_W-1:0] TT_SPILL_NORMAL = 9'h080;
  localparam logic [TT_W-1:0] TT_SPILL_OTHER  = 9'h0A0;
  localparam logic [TT_W-1:0] TT_FILL_NORMAL  = 9'h0C0;
  localparam logic [TT_W-1:0] TT_FILL_OTHER   = 9'h0E0;
  localparam logic [TT_W-1:0] TT_CLEAN_WIN    = 9'h024;
  localparam logic [TT_W-1:0] TT_MISALIGN     = 9'h034;

  // Strobes from the decision logic to the state registers.
  typedef struct packed {
    logic            stepUp;
    logic            stepDown;
    logic            wrFire;
    fieldSel_e       wrField;
    logic            trapFire;
    logic [TT_W-1:0] trapCode;
    logic            retFire;
  } winCmd_t;

  // Merge a selector field into bits 4:2 of a spill/fill base.
  function automatic logic [TT_W-1:0] mergeSel(
    input logic [TT_W-1:0] base,
    input logic [2:0]      sel
  );
    return base | {{(TT_W-5){1'b0}}, sel, 2'b00};
  endfunction

endpackage

// File: rtl/rw_control.sv
module rw_control
  import regwin_pkg::*;
#(
  parameter int CWP_W = 3
) (
  input  logic             saveReq,
  input  logic             restoreReq,
  input  logic             returnReq,
  input  logic [1:0]       targetLow,
  input  logic             wrEn,
  input  logic [2:0]       wrSel,
  input  logic [CWP_W-1:0] canSave,
  input  logic [CWP_W-1:0] canRestore,
  input  logic [CWP_W-1:0] cleanWin,
  input  logic [CWP_W-1:0] otherWin,
  input  logic [2:0]       wstateNormal,
  input  logic [2:0]       wstateOther,
  output winCmd_t          cmd
);

  logic            otherActive;
  logic [TT_W-1:0] spillCode;
  logic [TT_W-1:0] fillCode;
  logic            retreatReq;
  logic            misaligned;

  assign otherActive = (otherWin != '0);
  assign spillCode   = otherActive ? mergeSel(TT_SPILL_OTHER, wstateOther)
                                   : mergeSel(TT_SPILL_NORMAL, wstateNormal);
  assign fillCode    = otherActive ? mergeSel(TT_FILL_OTHER, wstateOther)
                                   : mergeSel(TT_FILL_NORMAL, wstateNormal);
  assign retreatReq  = restoreReq | returnReq;
  assign misaligned  = !restoreReq && returnReq && (targetLow != 2'b00);

  always_comb begin
    cmd = '0;
    cmd.wrField = FLD_CWP;
    if (saveReq) begin
      if (canSave == '0) begin
        cmd.trapFire = 1'b1;
        cmd.trapCode = spillCode;
      end else if (cleanWin == canRestore) begin
        cmd.trapFire = 1'b1;
        cmd.trapCode = TT_CLEAN_WIN;
      end else begin
        cmd.stepUp = 1'b1;
      end
    end else if (retreatReq) begin
      if (misaligned) begin
        cmd.trapFire = 1'b1;
        cmd.trapCode = TT_MISALIGN;
      end else if (canRestore == '0) begin
        cmd.trapFire = 1'b1;
        cmd.trapCode = fillCode;
      end else begin
        cmd.stepDown = 1'b1;
        cmd.retFire  = !restoreReq;
      end
    end else if (wrEn) begin
      cmd.wrFire  = 1'b1;
      cmd.wrField = fieldSel_e'(wrSel);
    end
  end

endmodule

// File: rtl/rw_datapath.sv
module rw_datapath
  import regwin_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter int ADDR_W  = 32,
  parameter int WR_W    = 8,
  localparam int CWP_W  = $clog2(NUM_WIN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  winCmd_t           cmd,
  input  logic [WR_W-1:0]   wrData,
  input  logic [ADDR_W-1:0] returnTarget,
  output logic [CWP_W-1:0]  cwp,
  output logic [CWP_W-1:0]  canSave,
  output logic [CWP_W-1:0]  canRestore,
  output logic [CWP_W-1:0]  cleanWin,
  output logic [CWP_W-1:0]  otherWin,
  output logic [2:0]        wstateNormal,
  output logic [2:0]        wstateOther,
  output logic              trapValid,
  output logic [TT_W-1:0]   trapType,
  output logic              retValid,
  output logic [ADDR_W-1:0] retTarget
);

  localparam logic [CWP_W-1:0] TOP_IDX    = CWP_W'(NUM_WIN - 1);
  localparam logic [CWP_W-1:0] SAVE_RESET = CWP_W'(NUM_WIN - 2);
  localparam logic [WR_W-1:0]  WIN_LIMIT  = WR_W'(NUM_WIN);

  function automatic logic [CWP_W-1:0] incMod(input logic [CWP_W-1:0] v);
    return (v == TOP_IDX) ? '0 : v + 1'b1;
  endfunction

  function automatic logic [CWP_W-1:0] decMod(input logic [CWP_W-1:0] v);
    return (v == '0) ? TOP_IDX : v - 1'b1;
  endfunction

  logic [CWP_W-1:0] cwpClamped;
  logic [CWP_W-1:0] wrCount;

  assign cwpClamped = (wrData >= WIN_LIMIT) ? TOP_IDX : wrData[CWP_W-1:0];
  assign wrCount    = wrData[CWP_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cwp          <= '0;
      canSave      <= SAVE_RESET;
      canRestore   <= '0;
      cleanWin     <= TOP_IDX;
      otherWin     <= '0;
      wstateNormal <= '0;
      wstateOther  <= '0;
    end else if (cmd.stepUp) begin
      cwp        <= incMod(cwp);
      canSave    <= decMod(canSave);
      canRestore <= incMod(canRestore);
    end else if (cmd.stepDown) begin
      cwp        <= decMod(cwp);
      canSave    <= incMod(canSave);
      canRestore <= decMod(canRestore);
    end else if (cmd.wrFire) begin
      case (cmd.wrField)
        FLD_CWP:        cwp        <= cwpClamped;
        FLD_CANSAVE:    canSave    <= wrCount;
        FLD_CANRESTORE: canRestore <= wrCount;
        FLD_CLEANWIN:   cleanWin   <= wrCount;
        FLD_OTHERWIN:   otherWin   <= wrCount;
        FLD_WSTATE: begin
          wstateNormal <= wrData[2:0];
          wstateOther  <= wrData[5:3];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trapValid <= 1'b0;
      trapType  <= '0;
      retValid  <= 1'b0;
      retTarget <= '0;
    end else begin
      trapValid <= cmd.trapFire;
      trapType  <= cmd.trapFire ? cmd.trapCode : '0;
      retValid  <= cmd.retFire;
      retTarget <= cmd.retFire ? returnTarget : '0;
    end
  end

endmodule

// File: rtl/regWindowCtrl.sv
module regWindowCtrl
  import regwin_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter int ADDR_W  = 32,
  parameter int WR_W    = 8,
  localparam int CWP_W  = $clog2(NUM_WIN)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              saveReq,
  input  logic              restoreReq,
  input  logic              returnReq,
  input  logic [ADDR_W-1:0] returnTarget,
  input  logic              wrEn,
  input  logic [2:0]        wrSel,
  input  logic [WR_W-1:0]   wrData,
  output logic [CWP_W-1:0]  cwp,
  output logic [CWP_W-1:0]  canSave,
  output logic [CWP_W-1:0]  canRestore,
  output logic [CWP_W-1:0]  cleanWin,
  output logic [CWP_W-1:0]  otherWin,
  output logic [2:0]        wstateNormal,
  output logic [2:0]        wstateOther,
  output logic              trapValid,
  output logic [8:0]        trapType,
  output logic              retValid,
  output logic [ADDR_W-1:0] retTarget
);

  winCmd_t cmd;

  rw_control #(.CWP_W(CWP_W)) u_control (
    .saveReq      (saveReq),
    .restoreReq   (restoreReq),
    .returnReq    (returnReq),
    .targetLow    (returnTarget[1:0]),
    .wrEn         (wrEn),
    .wrSel        (wrSel),
    .canSave      (canSave),
    .canRestore   (canRestore),
    .cleanWin     (cleanWin),
    .otherWin     (otherWin),
    .wstateNormal (wstateNormal),
    .wstateOther  (wstateOther),
    .cmd          (cmd)
  );

  rw_datapath #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .WR_W(WR_W)) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .cmd          (cmd),
    .wrData       (wrData),
    .returnTarget (returnTarget),
    .cwp          (cwp),
    .canSave      (canSave),
    .canRestore   (canRestore),
    .cleanWin     (cleanWin),
    .otherWin     (otherWin),
    .wstateNormal (wstateNormal),
    .wstateOther  (wstateOther),
    .trapValid    (trapValid),
    .trapType     (trapType),
    .retValid     (retValid),
    .retTarget    (retTarget)
  );

endmodule

// File: rtl/rw_checker.sv
module rw_checker #(
  parameter int NUM_WIN = 8,
  parameter int ADDR_W  = 32,
  localparam int CWP_W  = $clog2(NUM_WIN)
) (
  input logic              clk,
  input logic              rstN,
  input logic              saveReq,
  input logic              restoreReq,
  input logic              returnReq,
  input logic [ADDR_W-1:0] returnTarget,
  input logic [CWP_W-1:0]  cwp,
  input logic [CWP_W-1:0]  canSave,
  input logic [CWP_W-1:0]  canRestore,
  input logic [CWP_W-1:0]  cleanWin,
  input logic              trapValid,
  input logic [8:0]        trapType,
  input logic              retValid
);

  localparam logic [CWP_W-1:0] TOP_IDX = CWP_W'(NUM_WIN - 1);

  // R2: a free, clean save advances the pointer without a trap
  p_save_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(saveReq) && $past(canSave) != '0
      && $past(cleanWin) != $past(canRestore))
    |-> (!trapValid && cwp == (($past(cwp) == TOP_IDX) ? '0 : $past(cwp) + 1'b1)));

  // R3: a save with nothing free yields a code in the spill range
  p_spill_r3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(saveReq) && $past(canSave) == '0)
    |-> (trapValid && trapType[8:6] == 3'b010 && trapType[1:0] == 2'b00));

  // R7: misaligned return traps ahead of any window check
  p_misalign_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(returnReq) && !$past(saveReq) && !$past(restoreReq)
      && $past(returnTarget[1:0]) != 2'b00)
    |-> (trapValid && trapType == 9'h034 && !retValid));

  // R8: a return report never coincides with a trap
  p_ret_excl_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(trapValid && retValid));

  // R9: the pointer always names an existing window
  p_cwp_range_r9: assert property (@(posedge clk) disable iff (!rstN)
    cwp <= TOP_IDX);

  // R11: a trap leaves the pointer and counters where they were
  p_trap_freeze_r11: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && trapValid)
    |-> ($stable(cwp) && $stable(canSave) && $stable(canRestore) && $stable(cleanWin)));

endmodule

bind regWindowCtrl rw_checker #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W)) u_rw_checker (
  .clk          (clk),
  .rstN         (rstN),
  .saveReq      (saveReq),
  .restoreReq   (restoreReq),
  .returnReq    (returnReq),
  .returnTarget (returnTarget),
  .cwp          (cwp),
  .canSave      (canSave),
  .canRestore   (canRestore),
  .cleanWin     (cleanWin),
  .trapValid    (trapValid),
  .trapType     (trapType),
  .retValid     (retValid)
);

// File: tb/test_regWindowCtrl.sv
module test_regWindowCtrl;

  localparam int N  = 8;
  localparam int AW = 32;
  localparam int CW = $clog2(N);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          saveReq = 1'b0, restoreReq = 1'b0, returnReq = 1'b0, wrEn = 1'b0;
  logic [AW-1:0] returnTarget = '0;
  logic [2:0]    wrSel = '0;
  logic [7:0]    wrData = '0;
  logic [CW-1:0] cwp, canSave, canRestore, cleanWin, otherWin;
  logic [2:0]    wstateNormal, wstateOther;
  logic          trapValid, retValid;
  logic [8:0]    trapType;
  logic [AW-1:0] retTarget;

  int checks = 0;
  int failures = 0;

  // behavioural model state
  int mCwp, mCs, mCr, mCl, mOw, mWn, mWo, mTv, mTt, mRv;
  longint mRt;

  always #5 clk = ~clk;

  regWindowCtrl #(.NUM_WIN(N), .ADDR_W(AW)) i_regWindowCtrl (
    .clk(clk), .rstN(rstN), .saveReq(saveReq), .restoreReq(restoreReq),
    .returnReq(returnReq), .returnTarget(returnTarget), .wrEn(wrEn),
    .wrSel(wrSel), .wrData(wrData), .cwp(cwp), .canSave(canSave),
    .canRestore(canRestore), .cleanWin(cleanWin), .otherWin(otherWin),
    .wstateNormal(wstateNormal), .wstateOther(wstateOther),
    .trapValid(trapValid), .trapType(trapType), .retValid(retValid),
    .retTarget(retTarget)
  );

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    chk(tag, "cwp", cwp, mCwp);
    chk(tag, "canSave", canSave, mCs);
    chk(tag, "canRestore", canRestore, mCr);
    chk(tag, "cleanWin", cleanWin, mCl);
    chk(tag, "otherWin", otherWin, mOw);
    chk(tag, "wstateNormal", wstateNormal, mWn);
    chk(tag, "wstateOther", wstateOther, mWo);
    chk(tag, "trapValid", trapValid, mTv);
    chk(tag, "trapType", trapType, mTt);
    chk(tag, "retValid", retValid, mRv);
    chk(tag, "retTarget", retTarget, mRt);
  endtask

  function automatic int spillFillCode(input bit fill);
    int base;
    if (mOw != 0) base = fill ? 'h0E0 : 'h0A0;
    else          base = fill ? 'h0C0 : 'h080;
    return base | (((mOw != 0) ? mWo : mWn) << 2);
  endfunction

  // Advance the model by one request, following the requirements.
  task automatic modelStep(input bit s, input bit r, input bit t, input longint tgt,
                           input bit we, input int sel, input int data);
    mTv = 0; mTt = 0; mRv = 0; mRt = 0;
    if (s) begin
      if (mCs == 0) begin mTv = 1; mTt = spillFillCode(1'b0); end
      else if (mCl == mCr) begin mTv = 1; mTt = 'h024; end
      else begin mCwp = (mCwp + 1) % N; mCs = (mCs + N - 1) % N; mCr = (mCr + 1) % N; end
    end else if (r || t) begin
      if (!r && (tgt % 4) != 0) begin mTv = 1; mTt = 'h034; end
      else if (mCr == 0) begin mTv = 1; mTt = spillFillCode(1'b1); end
      else begin
        mCwp = (mCwp + N - 1) % N; mCs = (mCs + 1) % N; mCr = (mCr + N - 1) % N;
        if (!r) begin mRv = 1; mRt = tgt; end
      end
    end else if (we) begin
      case (sel)
        0: mCwp = (data >= N) ? N - 1 : data;
        1: mCs = data % (1 << CW);
        2: mCr = data % (1 << CW);
        3: mCl = data % (1 << CW);
        4: mOw = data % (1 << CW);
        5: begin mWn = data % 8; mWo = (data / 8) % 8; end
        default: ;
      endcase
    end
  endtask

  // Drive one cycle of stimulus from a falling edge, check at the next falling edge.
  task automatic cyc(input string tag, input bit s, input bit r, input bit t,
                     input longint tgt, input bit we, input int sel, input int data);
    saveReq = s; restoreReq = r; returnReq = t; returnTarget = AW'(tgt);
    wrEn = we; wrSel = 3'(sel); wrData = 8'(data);
    modelStep(s, r, t, tgt, we, sel, data);
    @(posedge clk);
    @(negedge clk);
    saveReq = 0; restoreReq = 0; returnReq = 0; wrEn = 0;
    compareAll(tag);
  endtask

  task automatic wr(input string tag, input int sel, input int data);
    cyc(tag, 0, 0, 0, 0, 1, sel, data);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    mCwp = 0; mCs = N - 2; mCr = 0; mCl = N - 1; mOw = 0; mWn = 0; mWo = 0;
    mTv = 0; mTt = 0; mRv = 0; mRt = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    compareAll("R1 reset");
    rstN = 1'b1;

    // R9: selector fields, then saves until the spill (R2, R3)
    wr("R9 wstate", 5, (5 << 3) | 3);
    for (int i = 0; i < N - 2; i++) cyc("R2 save", 1, 0, 0, 0, 0, 0, 0);
    cyc("R3 spill normal", 1, 0, 0, 0, 0, 0, 0);
    wr("R9 otherwin", 4, 2);
    cyc("R3 spill other", 1, 0, 0, 0, 0, 0, 0);
    // R4: clean-window trap with saves still free
    wr("R9 cansave", 1, 3);
    wr("R9 otherwin", 4, 0);
    wr("R9 cleanwin", 3, N - 2);
    cyc("R4 clean", 1, 0, 0, 0, 0, 0, 0);
    // R6 / R8: restores and aligned returns down to empty
    cyc("R6 restore", 0, 1, 0, 0, 0, 0, 0);
    cyc("R8 return ok", 0, 0, 1, 'h4000_1000, 0, 0, 0);
    for (int i = 0; i < N - 4; i++) cyc("R6 restore", 0, 1, 0, 0, 0, 0, 0);
    cyc("R5 fill normal", 0, 1, 0, 0, 0, 0, 0);
    cyc("R5 fill return", 0, 0, 1, 'h800, 0, 0, 0);
    // R7: misaligned wins over the fill condition
    cyc("R7 misalign", 0, 0, 1, 'h1002, 0, 0, 0);
    wr("R9 otherwin", 4, 1);
    cyc("R5 fill other", 0, 1, 0, 0, 0, 0, 0);
    cyc("R7 misalign", 0, 0, 1, 'h1001, 0, 0, 0);
    // R9: pointer clamp and wrap-around (R2, R6)
    wr("R9 cwp clamp", 0, 12);
    wr("R9 cwp exact", 0, N);
    wr("R9 cansave", 1, 4);
    wr("R9 cleanwin", 3, 7);
    wr("R9 otherwin", 4, 0);
    cyc("R2 save wrap", 1, 0, 0, 0, 0, 0, 0);
    cyc("R6 restore wrap", 0, 1, 0, 0, 0, 0, 0);
    cyc("R6 restore wrap", 0, 1, 0, 0, 0, 0, 0);
    wr("R9 cwp", 0, 5);
    wr("R9 rsvd6 ignored", 6, 'h3F);
    wr("R9 rsvd7 ignored", 7, 'h15);
    // R10: colliding strobes
    cyc("R10 save over restore", 1, 1, 0, 0, 0, 0, 0);
    cyc("R10 restore over return", 0, 1, 1, 'h20, 0, 0, 0);
    cyc("R10 return over write", 0, 0, 1, 'h44, 1, 0, 2);
    cyc("R10 save over write", 1, 0, 0, 0, 1, 5, 'h3F);
    // R11: back-to-back traps stay single-cycle pulses
    wr("R9 canrestore", 2, 0);
    cyc("R11 trap", 0, 1, 0, 0, 0, 0, 0);
    cyc("R11 idle", 0, 0, 0, 0, 0, 0, 0);

    // R10/R11 mixed pseudo-random traffic
    for (int i = 0; i < 600; i++) begin
      int k;
      k = $urandom_range(0, 9);
      cyc("R10 random", k < 3, k == 3 || k == 4, k == 5 || k == 6,
          longint'($urandom_range(0, 255)), k >= 6, $urandom_range(0, 7),
          $urandom_range(0, 63));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule